// File: doc/BRIEF.md
# Dual-Clock Operating Mode Controller

This block keeps track of which operating mode a small controller core is in when it has two clock sources: a fast gear clock and a slow low-frequency clock. From a few software-written control bits, an idle request and a wake-up event, it decides which mode is active. It then drives the selects and enables that the clock tree, the prescaler, the divider chain, the CPU and the watchdog need. The oscillators and the glitch-free clock multiplexers are outside this block. They see only the select and enable outputs.

The block starts in single-clock operation. Once software reports that the low-frequency oscillator is running, the block moves to the full-speed dual mode. From there it can enter a slow mode with the fast oscillator still running. From that slow mode it can go on to a slow mode with the fast oscillator stopped. Separately, from full speed it can enter an idle mode, in which the CPU and the watchdog halt. In both slow modes the core and the peripherals run from the low-frequency clock divided by four. Mode changes take effect only on a machine-cycle boundary.

The block is clocked by a reference clock. The low-frequency clock reaches it as a one-cycle tick input, `lf_tick`. In the slow modes a machine-cycle boundary falls on every fourth tick. In every other mode, each reference clock cycle is a boundary.

Top module: `dcm_top`

## Requirements
- R1: While `rst_n` is low and just after it is released, the outputs hold these values: `mode_o`=0 (single), `hf_osc_en`=1, `presc_en`=1, all `div_en` bits 1, `cpu_clk_lf`=0, `per_clk_lf`=0, `cpu_halt`=0, `wdt_halt`=0 and `per_rst_hold`=0.
- R2: Mode codes on `mode_o` are: 0 single, 1 full-speed dual, 2 slow with the fast oscillator on, 3 slow with the fast oscillator off, 4 idle. In single mode with `lf_run`=1, the mode becomes 1 after the next clock edge.
- R3: In modes 1 and 4, `cpu_clk_lf`=0 and `per_clk_lf` equals the `per_sel_lf` input. In mode 0 both selects are 0.
- R4: In mode 1, `sel_slow`=1 with `lf_run`=1 moves the mode to 2, and in mode 2 `sel_slow`=0 moves it back to 1. `sel_slow` has no effect in mode 0.
- R5: In mode 2, `hf_keep`=0 moves the mode to 3. In mode 3, `hf_keep`=1 moves it back to 2. `hf_osc_en` is 0 only in mode 3.
- R6: In mode 1, `hf_keep`=0 is ignored: the mode stays 1 and `hf_osc_en` stays 1.
- R7: In modes 2 and 3 the outputs are `cpu_clk_lf`=1, `per_clk_lf`=1, `presc_en`=0, every `div_en` bit 0 and `per_rst_hold`=1. In all other modes `presc_en`=1, every `div_en` bit is 1 and `per_rst_hold`=0.
- R8: `mc_tick` marks machine-cycle boundaries, and `mode_o` changes only after an edge at which `mc_tick` was 1. In modes 2 and 3, `mc_tick` is 1 on every fourth `lf_tick`, counted from reset. In all other modes it is 1 on every cycle.
- R9: `idle_req` moves the mode to 4 only from mode 1. In mode 4, `cpu_halt`=1 and `wdt_halt`=1. In every other mode both are 0.
- R10: In mode 4, `wake`=1 returns the mode to 1 after the next clock edge.
- R11: Priority in mode 1 is `idle_req`, then `sel_slow` (needs `lf_run`=1), then `lf_run`=0. The last case returns the mode to 0.
- R12: In mode 3, `sel_slow`=0 is ignored. The mode stays 3 until `hf_keep` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | One-cycle pulse per low-frequency clock period |
| lf_run | input | 1 | Software bit: low-frequency oscillator started |
| sel_slow | input | 1 | Software bit: clock select, slow when 1 |
| hf_keep | input | 1 | Software bit: fast oscillator kept running |
| per_sel_lf | input | 1 | Peripheral clock choice in full-speed and idle modes |
| idle_req | input | 1 | Idle entry request |
| wake | input | 1 | Wake-up event |
| mode_o | output | 3 | Active mode code |
| mc_tick | output | 1 | Machine-cycle boundary marker |
| cpu_clk_lf | output | 1 | CPU runs on low-frequency clock divided by four |
| per_clk_lf | output | 1 | Peripherals run on low-frequency clock divided by four |
| hf_osc_en | output | 1 | Fast oscillator enable |
| presc_en | output | 1 | Prescaler output enable |
| div_en | output | DIV_STAGES | Enables for the lower divider stages |
| cpu_halt | output | 1 | CPU halted |
| wdt_halt | output | 1 | Watchdog halted |
| per_rst_hold | output | 1 | Selected peripherals held in reset |

## Verification
The bench targets the transitions that are easy to get wrong:
- Clearing the oscillator bit at full speed. A faulty design would stop the clock the CPU is running on.
- Clearing the clock select while the fast oscillator is off. A faulty design would jump straight to full speed on a dead oscillator.
- Requesting idle from a slow mode. A faulty design would halt the CPU where it must not.
- Raising `idle_req` and `sel_slow` in the same cycle. A faulty priority order would pick the slow mode.

Slow-mode changes are checked against the divide-by-four boundary. A design that switched on the first tick, or on every clock, would differ from the model on the cycle of the change.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [2:0] {
        MODE_SINGLE  = 3'd0,
        MODE_FULL    = 3'd1,
        MODE_SLOW_HF = 3'd2,
        MODE_SLOW_LF = 3'd3,
        MODE_IDLE    = 3'd4
    } mode_e;

    function automatic logic is_slow(mode_e m);
        return (m == MODE_SLOW_HF) || (m == MODE_SLOW_LF);
    endfunction

endpackage

// File: rtl/dcm_mc_timer.sv
module dcm_mc_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_tick,
    input  logic slow,
    output logic mc_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (lf_tick) begin
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
        mc_tick = slow ? (lf_tick && (s_q.cnt == LAST)) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dcm_mode_fsm.sv
module dcm_mode_fsm
    import dcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mc_tick,
    input  logic  lf_run,
    input  logic  sel_slow,
    input  logic  hf_keep,
    input  logic  idle_req,
    input  logic  wake,
    output mode_e mode
);
    typedef struct packed {
        mode_e mode;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mc_tick) begin
            unique case (s_q.mode)
                MODE_SINGLE: begin
                    if (lf_run) s_d.mode = MODE_FULL;
                end
                MODE_FULL: begin
                    if (idle_req)                s_d.mode = MODE_IDLE;
                    else if (sel_slow && lf_run) s_d.mode = MODE_SLOW_HF;
                    else if (!lf_run)            s_d.mode = MODE_SINGLE;
                end
                MODE_SLOW_HF: begin
                    if (!sel_slow)     s_d.mode = MODE_FULL;
                    else if (!hf_keep) s_d.mode = MODE_SLOW_LF;
                end
                MODE_SLOW_LF: begin
                    if (hf_keep) s_d.mode = MODE_SLOW_HF;
                end
                MODE_IDLE: begin
                    if (wake) s_d.mode = MODE_FULL;
                end
                default: s_d.mode = MODE_SINGLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mode: MODE_SINGLE};
        else        s_q <= s_d;
    end

    assign mode = s_q.mode;
endmodule

// File: rtl/dcm_out_decode.sv
module dcm_out_decode
    import dcm_pkg::*;
#(
    parameter int DIV_STAGES = 8
) (
    input  mode_e                  mode,
    input  logic                   per_sel_lf,
    output logic                   cpu_clk_lf,
    output logic                   per_clk_lf,
    output logic                   hf_osc_en,
    output logic                   presc_en,
    output logic [DIV_STAGES-1:0]  div_en,
    output logic                   cpu_halt,
    output logic                   wdt_halt,
    output logic                   per_rst_hold
);
    logic slow;
    logic dual_fast;

    always_comb begin
        slow         = is_slow(mode);
        dual_fast    = (mode == MODE_FULL) || (mode == MODE_IDLE);
        cpu_clk_lf   = slow;
        per_clk_lf   = slow || (dual_fast && per_sel_lf);
        hf_osc_en    = (mode != MODE_SLOW_LF);
        presc_en     = !slow;
        cpu_halt     = (mode == MODE_IDLE);
        wdt_halt     = (mode == MODE_IDLE);
        per_rst_hold = slow;
    end

    for (genvar g = 0; g < DIV_STAGES; g++) begin : g_div
        assign div_en[g] = !slow;
    end
endmodule

// File: rtl/dcm_top.sv
module dcm_top
    import dcm_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int DIV_STAGES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lf_tick,
    input  logic                  lf_run,
    input  logic                  sel_slow,
    input  logic                  hf_keep,
    input  logic                  per_sel_lf,
    input  logic                  idle_req,
    input  logic                  wake,
    output logic [2:0]            mode_o,
    output logic                  mc_tick,
    output logic                  cpu_clk_lf,
    output logic                  per_clk_lf,
    output logic                  hf_osc_en,
    output logic                  presc_en,
    output logic [DIV_STAGES-1:0] div_en,
    output logic                  cpu_halt,
    output logic                  wdt_halt,
    output logic                  per_rst_hold
);
    mode_e mode;

    dcm_mc_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lf_tick (lf_tick),
        .slow    (is_slow(mode)),
        .mc_tick (mc_tick)
    );

    dcm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .lf_run   (lf_run),
        .sel_slow (sel_slow),
        .hf_keep  (hf_keep),
        .idle_req (idle_req),
        .wake     (wake),
        .mode     (mode)
    );

    dcm_out_decode #(.DIV_STAGES(DIV_STAGES)) u_dec (
        .mode         (mode),
        .per_sel_lf   (per_sel_lf),
        .cpu_clk_lf   (cpu_clk_lf),
        .per_clk_lf   (per_clk_lf),
        .hf_osc_en    (hf_osc_en),
        .presc_en     (presc_en),
        .div_en       (div_en),
        .cpu_halt     (cpu_halt),
        .wdt_halt     (wdt_halt),
        .per_rst_hold (per_rst_hold)
    );

    assign mode_o = mode;
endmodule

// File: rtl/dcm_check.sv
module dcm_check #(
    parameter int DIV_STAGES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hf_keep,
    input logic                  wake,
    input logic [2:0]            mode_o,
    input logic                  mc_tick,
    input logic                  cpu_clk_lf,
    input logic                  per_clk_lf,
    input logic                  hf_osc_en,
    input logic                  presc_en,
    input logic [DIV_STAGES-1:0] div_en,
    input logic                  cpu_halt,
    input logic                  wdt_halt,
    input logic                  per_rst_hold
);
    p_osc_off_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> !hf_osc_en);

    p_osc_kept_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> hf_osc_en);

    p_slow_gating_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 || mode_o == 3'd3) |->
            (!presc_en && div_en == '0 && per_rst_hold && cpu_clk_lf && per_clk_lf));

    p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_tick |=> $stable(mode_o));

    p_idle_from_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> ($past(mode_o) == 3'd1));

    p_halt_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (wdt_halt && mode_o == 3'd4));

    p_wake_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && wake) |=> (mode_o == 3'd1));

    p_lf_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && !hf_keep) |=> (mode_o == 3'd3));
endmodule

bind dcm_top dcm_check #(.DIV_STAGES(DIV_STAGES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hf_keep      (hf_keep),
    .wake         (wake),
    .mode_o       (mode_o),
    .mc_tick      (mc_tick),
    .cpu_clk_lf   (cpu_clk_lf),
    .per_clk_lf   (per_clk_lf),
    .hf_osc_en    (hf_osc_en),
    .presc_en     (presc_en),
    .div_en       (div_en),
    .cpu_halt     (cpu_halt),
    .wdt_halt     (wdt_halt),
    .per_rst_hold (per_rst_hold)
);

// File: tb/tb_dcm_top.sv
module tb_dcm_top;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lf_tick = 1'b0;
    logic lf_run = 1'b0, sel_slow = 1'b0, hf_keep = 1'b1, per_sel_lf = 1'b0;
    logic idle_req = 1'b0, wake = 1'b0;
    logic [2:0] mode_o;
    logic mc_tick, cpu_clk_lf, per_clk_lf, hf_osc_en, presc_en;
    logic [NS-1:0] div_en;
    logic cpu_halt, wdt_halt, per_rst_hold;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dcm_top #(.DIV(4), .DIV_STAGES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .lf_run(lf_run),
        .sel_slow(sel_slow), .hf_keep(hf_keep), .per_sel_lf(per_sel_lf),
        .idle_req(idle_req), .wake(wake), .mode_o(mode_o), .mc_tick(mc_tick),
        .cpu_clk_lf(cpu_clk_lf), .per_clk_lf(per_clk_lf), .hf_osc_en(hf_osc_en),
        .presc_en(presc_en), .div_en(div_en), .cpu_halt(cpu_halt),
        .wdt_halt(wdt_halt), .per_rst_hold(per_rst_hold)
    );

    // Low-frequency ticks: one every third reference cycle
    int tk = 0;
    always @(posedge clk) begin
        #1;
        tk = (tk + 1) % 3;
        lf_tick = (tk == 0);
    end

    // Behavioural reference model
    int m_mode = 0;
    int m_cnt = 0;
    function automatic bit m_slow(int m);
        return m == 2 || m == 3;
    endfunction
    function automatic bit m_tick();
        return m_slow(m_mode) ? (lf_tick && m_cnt == 3) : 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_cnt = 0;
        end else begin
            int nxt;
            nxt = m_mode;
            if (m_tick()) begin
                case (m_mode)
                    0: if (lf_run) nxt = 1;
                    1: if (idle_req) nxt = 4;
                       else if (sel_slow && lf_run) nxt = 2;
                       else if (!lf_run) nxt = 0;
                    2: if (!sel_slow) nxt = 1;
                       else if (!hf_keep) nxt = 3;
                    3: if (hf_keep) nxt = 2;
                    4: if (wake) nxt = 1;
                    default: nxt = 0;
                endcase
            end
            if (lf_tick) m_cnt = (m_cnt + 1) % 4;
            m_mode = nxt;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit sl;
            sl = m_slow(m_mode);
            chk("R2", "mode_o", mode_o, m_mode);
            chk("R8", "mc_tick", mc_tick, m_tick());
            chk("R3", "cpu_clk_lf", cpu_clk_lf, sl);
            chk("R3", "per_clk_lf", per_clk_lf,
                sl || ((m_mode == 1 || m_mode == 4) && per_sel_lf));
            chk("R5", "hf_osc_en", hf_osc_en, m_mode != 3);
            chk("R7", "presc_en", presc_en, !sl);
            chk("R7", "div_en", div_en, sl ? 0 : (1 << NS) - 1);
            chk("R7", "per_rst_hold", per_rst_hold, sl);
            chk("R9", "cpu_halt", cpu_halt, m_mode == 4);
            chk("R9", "wdt_halt", wdt_halt, m_mode == 4);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_mode(int exp, int maxc, string tag);
        int k = 0;
        while (mode_o != exp && k < maxc) begin
            step(1);
            k++;
        end
        chk(tag, "mode reached", mode_o, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset values
        chk("R1", "mode_o", mode_o, 0);
        chk("R1", "hf_osc_en", hf_osc_en, 1);
        chk("R1", "presc_en", presc_en, 1);
        chk("R1", "div_en", div_en, (1 << NS) - 1);
        chk("R1", "halt", {cpu_halt, wdt_halt, per_rst_hold, cpu_clk_lf, per_clk_lf}, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "mode after release", mode_o, 0);

        // R4: sel_slow ignored in single mode
        sel_slow = 1'b1;
        step(4);
        chk("R4", "single ignores sel_slow", mode_o, 0);
        sel_slow = 1'b0;

        // R2: single to full-speed
        lf_run = 1'b1;
        step(1);
        chk("R2", "enter full", mode_o, 1);

        // R3: peripheral select follows input
        per_sel_lf = 1'b1;
        step(1);
        chk("R3", "per_clk_lf", per_clk_lf, 1);
        chk("R3", "cpu_clk_lf", cpu_clk_lf, 0);

        // R6: oscillator clear ignored at full speed
        hf_keep = 1'b0;
        step(4);
        chk("R6", "mode", mode_o, 1);
        chk("R6", "hf_osc_en", hf_osc_en, 1);
        hf_keep = 1'b1;

        // R9 / R10: idle entry and wake
        idle_req = 1'b1;
        step(1);
        idle_req = 1'b0;
        chk("R9", "idle mode", mode_o, 4);
        chk("R9", "cpu_halt", cpu_halt, 1);
        chk("R9", "wdt_halt", wdt_halt, 1);
        chk("R3", "per_clk_lf in idle", per_clk_lf, 1);
        step(3);
        chk("R10", "stays idle without wake", mode_o, 4);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R10", "wake release", mode_o, 1);

        // R11: idle wins over slow
        idle_req = 1'b1;
        sel_slow = 1'b1;
        step(1);
        idle_req = 1'b0;
        chk("R11", "idle priority", mode_o, 4);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R10", "wake to full", mode_o, 1);

        // R4 / R8: enter slow on a machine-cycle boundary
        wait_mode(2, 20, "R4");
        chk("R7", "presc_en", presc_en, 0);
        chk("R7", "per_rst_hold", per_rst_hold, 1);

        // R9: idle request ignored in slow
        idle_req = 1'b1;
        step(20);
        idle_req = 1'b0;
        chk("R9", "no idle from slow", mode_o, 2);
        chk("R9", "cpu_halt", cpu_halt, 0);

        // R5: stop fast oscillator
        hf_keep = 1'b0;
        wait_mode(3, 20, "R5");
        chk("R5", "hf_osc_en", hf_osc_en, 0);

        // R12: select clear ignored while oscillator off
        sel_slow = 1'b0;
        step(30);
        chk("R12", "stays slow-lf", mode_o, 3);

        // R5 / R4: restart oscillator, then back to full speed
        hf_keep = 1'b1;
        wait_mode(2, 20, "R5");
        wait_mode(1, 20, "R4");
        chk("R7", "presc_en back", presc_en, 1);

        // R11: dropping lf_run returns to single
        lf_run = 1'b0;
        step(1);
        chk("R11", "back to single", mode_o, 0);
        step(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule